// File: doc/BRIEF.md
# SPI Message Sequencer

This block runs a complete SPI message, built from one or more transfers, on top of a byte-level shift engine. No processor has to step in for each byte. Transfer descriptors arrive on a ready/valid queue. Each descriptor carries:

- a byte count;
- a flag that says whether the transfer supplies transmit data;
- a delay in microseconds to apply after the transfer;
- a flag that releases chip select before the next transfer;
- a flag that marks the final transfer of the message.

The sequencer launches bytes into the engine and pulls transmit bytes from a stream. It hands every received byte out on a one-cycle strobe and drives the active-low chip select. When a message ends, it pulses a completion strobe together with an ok/error flag and the number of bytes in the transfers that finished.

The engine reports each byte with one of three pulses: byte complete, write collision, or mode fault. A collision resends the byte that was just launched. A mode fault ends the message with an error. The microsecond timer is derived from the system clock by the `CLKS_PER_US` parameter. `SCK_CLKS` sets the minimum chip-select high time between transfers, given in clocks of one SCK period.

Top module: `spi_msg_sequencer`

## Requirements
- R1: After reset, chip select is high (`csN`=1), `engStart`, `rxValid` and `msgDone` are 0, and `descReady` is 1.
- R2: When a descriptor is accepted, `csN` goes low in the same cycle that `engStart` first pulses. The launched byte is the next transmit-stream byte, popped with `txPop`, if the has-TX flag is 1. Otherwise it is 0x00 and nothing is popped.
- R3: A byte-complete pulse makes the received byte appear on `rxData` with `rxValid` one cycle later. In that same cycle, if bytes remain, the next byte is launched (a stream byte or 0x00, as in R2).
- R4: A collision pulse is answered one cycle later by an `engStart` carrying the same byte as before. No stream byte is consumed and `rxValid` stays 0. Collision takes priority over fault, and fault takes priority over byte complete.
- R5: A fault pulse during a transfer raises `csN` and pulses `msgDone` with `msgOk`=0 one cycle later. `msgBytes` then equals the summed lengths of the transfers of that message that had already finished. The sequencer returns to idle.
- R6: With delay d and a chip-select-change flag of 0, the next transfer's first `engStart` comes exactly d*CLKS_PER_US+2 cycles after the last `rxValid` of the previous transfer. With d=0 this is 2 cycles.
- R7: After the final transfer's delay has run out, `csN` rises and `msgDone` pulses with `msgOk`=1. `msgBytes` equals the sum of all transfer lengths in the message.
- R8: Between transfers of one message, `csN` stays low unless the finished transfer had its chip-select-change flag set. If it was set, `csN` is high for at least SCK_CLKS cycles, and the next launch comes d*CLKS_PER_US+2+SCK_CLKS cycles after the last `rxValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| descValid | input | 1 | Descriptor available |
| descReady | output | 1 | Sequencer can take a descriptor |
| descLen | input | LEN_W | Transfer byte count (1 or more) |
| descHasTx | input | 1 | Transfer takes bytes from the TX stream |
| descCsChange | input | 1 | Release chip select after this transfer |
| descDelayUs | input | DLY_W | Post-transfer delay in microseconds |
| descLast | input | 1 | Final transfer of the message |
| txData | input | DATA_W | Head of the transmit stream |
| txPop | output | 1 | Head byte consumed this cycle |
| rxData | output | DATA_W | Received byte |
| rxValid | output | 1 | rxData valid strobe |
| engStart | output | 1 | Launch a byte in the shift engine |
| engTxByte | output | DATA_W | Byte to shift out |
| engByteDone | input | 1 | Engine finished a byte |
| engRxByte | input | DATA_W | Byte shifted in by the engine |
| engCollide | input | 1 | Engine reports a write collision |
| engFault | input | 1 | Engine reports a mode fault |
| csN | output | 1 | Active-low chip select |
| msgDone | output | 1 | Message completion strobe |
| msgOk | output | 1 | 1 on success, 0 after a fault |
| msgBytes | output | CNT_W | Bytes in completed transfers of the message |

## Verification
The embedded assertions check, on every cycle:

- chip select is high in the idle and gap states and low while bytes move;
- the wait state cannot be left while delay remains;
- a collision relaunches the unchanged byte;
- an error completion always follows a fault.

Only the bench scenarios can show the exact launch spacing after each delay, the TX pops and the zero-fill, the received data, the per-message byte totals, and the minimum chip-select high time. It checks these against a reference engine model that injects collisions and a late fault.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_WAIT,
    ST_GAP,
    ST_FETCH
  } seqState_t;

  typedef struct packed {
    logic sendNew;
    logic useTx;
    logic resend;
    logic storeRx;
    logic clrBytes;
    logic addBytes;
  } seqStrobe_t;

endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int LEN_W       = 8,
  parameter int DLY_W       = 8,
  parameter int CLKS_PER_US = 100,
  parameter int SCK_CLKS    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descValid,
  output logic             descReady,
  input  logic [LEN_W-1:0] descLen,
  input  logic             descHasTx,
  input  logic             descCsChange,
  input  logic [DLY_W-1:0] descDelayUs,
  input  logic             descLast,
  input  logic             engByteDone,
  input  logic             engCollide,
  input  logic             engFault,
  output logic             csN,
  output logic             msgDone,
  output logic             msgOk,
  output seqStrobe_t       strobe,
  output logic [LEN_W-1:0] curLen
);

  localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam int GAP_W = (SCK_CLKS > 1) ? $clog2(SCK_CLKS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'(SCK_CLKS - 1);

  seqState_t        state;
  logic [LEN_W-1:0] remLen;
  logic [DLY_W-1:0] curDly, dlyCnt;
  logic [PRE_W-1:0] preCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             curHasTx, curCsChg, curLast;
  logic             accept, byteOk, lastByte, delayOver;

  assign descReady = (state == ST_IDLE) || (state == ST_FETCH);
  assign accept    = descReady && descValid;
  // collision outranks fault, fault outranks byte completion
  assign byteOk    = (state == ST_XFER) && !engCollide && !engFault && engByteDone;
  assign lastByte  = (remLen == LEN_W'(1));
  assign delayOver = (state == ST_WAIT) && (dlyCnt == '0);

  always_comb begin
    strobe          = '0;
    strobe.sendNew  = accept || (byteOk && !lastByte);
    strobe.useTx    = accept ? descHasTx : curHasTx;
    strobe.resend   = (state == ST_XFER) && engCollide;
    strobe.storeRx  = byteOk;
    strobe.clrBytes = accept && (state == ST_IDLE);
    strobe.addBytes = delayOver;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      msgDone  <= 1'b0;
      msgOk    <= 1'b0;
      remLen   <= '0;
      curLen   <= '0;
      curDly   <= '0;
      dlyCnt   <= '0;
      preCnt   <= '0;
      gapCnt   <= '0;
      curHasTx <= 1'b0;
      curCsChg <= 1'b0;
      curLast  <= 1'b0;
    end else begin
      msgDone <= 1'b0;
      case (state)
        ST_IDLE, ST_FETCH: begin
          if (accept) begin
            remLen   <= descLen;
            curLen   <= descLen;
            curDly   <= descDelayUs;
            curHasTx <= descHasTx;
            curCsChg <= descCsChange;
            curLast  <= descLast;
            csN      <= 1'b0;
            state    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (engCollide) begin
            state <= ST_XFER;
          end else if (engFault) begin
            csN     <= 1'b1;
            msgDone <= 1'b1;
            msgOk   <= 1'b0;
            state   <= ST_IDLE;
          end else if (engByteDone) begin
            remLen <= remLen - LEN_W'(1);
            if (lastByte) begin
              dlyCnt <= curDly;
              preCnt <= '0;
              state  <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (delayOver) begin
            if (curLast) begin
              csN     <= 1'b1;
              msgDone <= 1'b1;
              msgOk   <= 1'b1;
              state   <= ST_IDLE;
            end else if (curCsChg) begin
              csN    <= 1'b1;
              gapCnt <= GAP_LOAD;
              state  <= ST_GAP;
            end else begin
              state <= ST_FETCH;
            end
          end else if (preCnt == PRE_LAST) begin
            preCnt <= '0;
            dlyCnt <= dlyCnt - DLY_W'(1);
          end else begin
            preCnt <= preCnt + PRE_W'(1);
          end
        end
        ST_GAP: begin
          if (gapCnt == '0) state <= ST_FETCH;
          else              gapCnt <= gapCnt - GAP_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: chip select released whenever no message is active
  assert_idle_cs_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> csN);

  // R2: chip select held while bytes move
  assert_xfer_cs_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER) |-> !csN);

  // R6: no exit from wait while delay remains
  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && dlyCnt != '0) |=> (state == ST_WAIT));

  // R8: chip select high during the separation gap
  assert_gap_cs_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> csN);

  // R5: an error completion is always caused by a fault pulse
  assert_error_from_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    (msgDone && !msgOk) |-> $past(engFault));

endmodule

// File: rtl/spi_seq_dp.sv
module spi_seq_dp
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [LEN_W-1:0]  curLen,
  input  logic [DATA_W-1:0] txData,
  output logic              txPop,
  output logic              engStart,
  output logic [DATA_W-1:0] engTxByte,
  input  logic [DATA_W-1:0] engRxByte,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic [CNT_W-1:0]  msgBytes
);

  logic [DATA_W-1:0] nextByte;

  assign txPop    = strobe.sendNew && strobe.useTx;
  assign nextByte = strobe.useTx ? txData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engStart  <= 1'b0;
      engTxByte <= '0;
      rxData    <= '0;
      rxValid   <= 1'b0;
      msgBytes  <= '0;
    end else begin
      // resend leaves engTxByte untouched so the same byte goes out again
      engStart <= strobe.sendNew || strobe.resend;
      if (strobe.sendNew) engTxByte <= nextByte;
      rxValid <= strobe.storeRx;
      if (strobe.storeRx) rxData <= engRxByte;
      if (strobe.clrBytes)      msgBytes <= '0;
      else if (strobe.addBytes) msgBytes <= msgBytes + CNT_W'(curLen);
    end
  end

  // R4: a collision relaunches the unchanged byte on the next cycle
  assert_resend_same_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resend |=> (engStart && $stable(engTxByte)));

  // R3: a new byte and a resend are never requested together
  assert_single_launch_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.sendNew, strobe.resend}));

  // R4: a resend never consumes stream data
  assert_resend_no_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resend |-> !txPop);

endmodule

// File: rtl/spi_msg_sequencer.sv
module spi_msg_sequencer
  import spi_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LEN_W       = 8,
  parameter int DLY_W       = 8,
  parameter int CNT_W       = 16,
  parameter int CLKS_PER_US = 100,
  parameter int SCK_CLKS    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              descValid,
  output logic              descReady,
  input  logic [LEN_W-1:0]  descLen,
  input  logic              descHasTx,
  input  logic              descCsChange,
  input  logic [DLY_W-1:0]  descDelayUs,
  input  logic              descLast,
  input  logic [DATA_W-1:0] txData,
  output logic              txPop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              engStart,
  output logic [DATA_W-1:0] engTxByte,
  input  logic              engByteDone,
  input  logic [DATA_W-1:0] engRxByte,
  input  logic              engCollide,
  input  logic              engFault,
  output logic              csN,
  output logic              msgDone,
  output logic              msgOk,
  output logic [CNT_W-1:0]  msgBytes
);

  seqStrobe_t       strobe;
  logic [LEN_W-1:0] curLen;

  spi_seq_ctrl #(
    .LEN_W(LEN_W), .DLY_W(DLY_W), .CLKS_PER_US(CLKS_PER_US), .SCK_CLKS(SCK_CLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .descValid(descValid), .descReady(descReady), .descLen(descLen),
    .descHasTx(descHasTx), .descCsChange(descCsChange),
    .descDelayUs(descDelayUs), .descLast(descLast),
    .engByteDone(engByteDone), .engCollide(engCollide), .engFault(engFault),
    .csN(csN), .msgDone(msgDone), .msgOk(msgOk),
    .strobe(strobe), .curLen(curLen)
  );

  spi_seq_dp #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curLen(curLen),
    .txData(txData), .txPop(txPop),
    .engStart(engStart), .engTxByte(engTxByte), .engRxByte(engRxByte),
    .rxData(rxData), .rxValid(rxValid), .msgBytes(msgBytes)
  );

endmodule

// File: tb/spi_msg_sequencer_test.sv
module spi_msg_sequencer_test;

  localparam int P       = 4;
  localparam int SCK     = 3;
  localparam int ENG_LAT = 3;
  localparam int COLL_AT = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       descValid, descReady, descHasTx, descCsChange, descLast;
  logic [7:0] descLen, descDelayUs, txData, rxData, engTxByte, engRxByte;
  logic       txPop, rxValid, engStart, engByteDone, engCollide, engFault;
  logic       csN, msgDone, msgOk;
  logic [15:0] msgBytes;

  always #5 clk = ~clk;

  spi_msg_sequencer #(.CLKS_PER_US(P), .SCK_CLKS(SCK)) uut (
    .clk(clk), .rstN(rstN),
    .descValid(descValid), .descReady(descReady), .descLen(descLen),
    .descHasTx(descHasTx), .descCsChange(descCsChange),
    .descDelayUs(descDelayUs), .descLast(descLast),
    .txData(txData), .txPop(txPop), .rxData(rxData), .rxValid(rxValid),
    .engStart(engStart), .engTxByte(engTxByte), .engByteDone(engByteDone),
    .engRxByte(engRxByte), .engCollide(engCollide), .engFault(engFault),
    .csN(csN), .msgDone(msgDone), .msgOk(msgOk), .msgBytes(msgBytes)
  );

  // stimulus tables
  logic [7:0] txMem  [0:1023];
  logic [7:0] expTx  [0:1023];
  int         expGap [0:1023];
  bit         expTgl [0:1023];
  int         dLen [0:255];
  int         dDly [0:255];
  bit         dTx [0:255];
  bit         dTgl [0:255];
  bit         dLast [0:255];
  int         expBytes [0:63];
  bit         expOk [0:63];
  int nDesc = 0, nExp = 0, txFill = 0, nMsg = 0, msgSum = 0;
  int pendGap = -1;
  bit pendTgl = 1'b0;
  int modfAt = -1;
  bit go = 1'b0;
  int dIdx = 0, txIdx = 0;

  int nChk = 0, nFail = 0;

  function automatic int launchGap(int dly, bit tgl);
    return dly * P + 2 + (tgl ? SCK : 0);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic addXfer(int len, bit hasTx, bit tgl, int dly, bit last);
    dLen[nDesc] = len; dTx[nDesc] = hasTx; dTgl[nDesc] = tgl;
    dDly[nDesc] = dly; dLast[nDesc] = last; nDesc++;
    for (int i = 0; i < len; i++) begin
      expTx[nExp]  = hasTx ? txMem[txFill] : 8'h00;
      if (hasTx) txFill++;
      expGap[nExp] = (i == 0) ? pendGap : -2;
      expTgl[nExp] = (i == 0) ? pendTgl : 1'b0;
      nExp++;
    end
    msgSum += len;
    if (last) begin
      expBytes[nMsg] = msgSum; expOk[nMsg] = 1'b1; nMsg++;
      msgSum = 0; pendGap = -1; pendTgl = 1'b0;
    end else begin
      pendGap = launchGap(dly, tgl); pendTgl = tgl;
    end
  endtask

  // descriptor queue and TX stream models
  assign descValid    = go && (dIdx < nDesc);
  assign descLen      = 8'(dLen[dIdx]);
  assign descDelayUs  = 8'(dDly[dIdx]);
  assign descHasTx    = dTx[dIdx];
  assign descCsChange = dTgl[dIdx];
  assign descLast     = dLast[dIdx];
  assign txData       = txMem[txIdx];

  always @(posedge clk) begin
    if (descValid && descReady) dIdx <= dIdx + 1;
    if (txPop) txIdx <= txIdx + 1;
  end

  // byte engine model
  int  engCnt, doneCnt;
  bit  engBusy, collDone;
  logic [7:0] held;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engBusy <= 1'b0; engCnt <= 0; doneCnt <= 0; collDone <= 1'b0; held <= 8'h00;
      engByteDone <= 1'b0; engCollide <= 1'b0; engFault <= 1'b0; engRxByte <= 8'h00;
    end else begin
      engByteDone <= 1'b0; engCollide <= 1'b0; engFault <= 1'b0;
      if (engStart) begin
        engBusy <= 1'b1; engCnt <= ENG_LAT; held <= engTxByte;
      end else if (engBusy) begin
        if (engCnt == 1) begin
          engBusy <= 1'b0;
          if (doneCnt == modfAt) engFault <= 1'b1;
          else if ((doneCnt == COLL_AT && !collDone) || ($urandom % 6 == 0)) begin
            engCollide <= 1'b1; collDone <= 1'b1;
          end else begin
            engByteDone <= 1'b1; engRxByte <= held ^ 8'h5A; doneCnt <= doneCnt + 1;
          end
        end else engCnt <= engCnt - 1;
      end
    end
  end

  // monitor, sampled at the falling edge
  int cyc = 0, tRx = 0, ptr = 0, mi = 0, csHigh = 0, nColl = 0;
  bit resendPend = 1'b0, collSeen = 1'b0;
  logic [7:0] lastSent = 8'h00;
  always @(negedge clk) begin
    if (rstN && go) begin
      cyc++;
      if (collSeen) chk(!rxValid, "R4 no rx after collision", int'(rxValid), 0);
      if (rxValid) begin
        chk(rxData == (lastSent ^ 8'h5A), "R3 rx data", int'(rxData), int'(lastSent ^ 8'h5A));
        tRx = cyc;
      end
      if (engStart) begin
        chk(!csN, "R2 cs low on launch", int'(csN), 0);
        if (resendPend) begin
          chk(engTxByte == lastSent, "R4 resend byte", int'(engTxByte), int'(lastSent));
          resendPend = 1'b0;
        end else begin
          chk(engTxByte == expTx[ptr], "R2 R3 launch byte", int'(engTxByte), int'(expTx[ptr]));
          if (expGap[ptr] >= 0) begin
            chk(cyc - tRx == expGap[ptr], expTgl[ptr] ? "R8 launch spacing" : "R6 launch spacing",
                cyc - tRx, expGap[ptr]);
            if (expTgl[ptr]) chk(csHigh >= SCK, "R8 cs high time", csHigh, SCK);
            else             chk(csHigh == 0, "R8 cs held low", csHigh, 0);
          end
          ptr++;
        end
        lastSent = engTxByte;
      end
      if (engCollide) begin resendPend = 1'b1; nColl++; end
      collSeen = engCollide;
      if (msgDone) begin
        chk(csN, expOk[mi] ? "R7 cs released" : "R5 cs released", int'(csN), 1);
        chk(msgOk == expOk[mi], expOk[mi] ? "R7 ok flag" : "R5 error flag", int'(msgOk), int'(expOk[mi]));
        chk(int'(msgBytes) == expBytes[mi], expOk[mi] ? "R7 byte total" : "R5 byte total",
            int'(msgBytes), expBytes[mi]);
        mi++;
      end
      if (csN) csHigh++; else csHigh = 0;
    end
  end

  initial begin
    int seedVal;
    int nx, base;
    seedVal = $urandom(32'd20240611);
    for (int i = 0; i < 1024; i++) txMem[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) begin
      dLen[i] = 1; dDly[i] = 0; dTx[i] = 0; dTgl[i] = 0; dLast[i] = 1;
    end
    // directed: zero-TX single byte, zero delay
    addXfer(1, 1'b0, 1'b0, 0, 1'b1);
    // directed: held cs with zero delay, toggled cs after delay, zero-fill tail
    addXfer(3, 1'b1, 1'b0, 0, 1'b0);
    addXfer(2, 1'b1, 1'b1, 2, 1'b0);
    addXfer(2, 1'b0, 1'b0, 1, 1'b1);
    // directed: toggle with zero delay, long final delay
    addXfer(2, 1'b1, 1'b1, 0, 1'b0);
    addXfer(1, 1'b1, 1'b0, 5, 1'b1);
    // random messages
    for (int m = 0; m < 8; m++) begin
      nx = 1 + int'($urandom % 3);
      for (int x = 0; x < nx; x++)
        addXfer(1 + int'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
                int'($urandom % 3), (x == nx - 1));
    end
    // directed fault on byte 2 of the second transfer
    base = nExp;
    addXfer(2, 1'b1, 1'b0, 1, 1'b0);
    addXfer(3, 1'b1, 1'b0, 0, 1'b1);
    expBytes[nMsg-1] = 2; expOk[nMsg-1] = 1'b0;
    modfAt = base + 3;

    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN, "R1 reset csN", int'(csN), 1);
    chk(!engStart, "R1 reset engStart", int'(engStart), 0);
    chk(!msgDone, "R1 reset msgDone", int'(msgDone), 0);
    chk(!rxValid, "R1 reset rxValid", int'(rxValid), 0);
    chk(descReady, "R1 reset descReady", int'(descReady), 1);
    go = 1'b1;

    for (int i = 0; i < 50000 && mi < nMsg; i++) @(posedge clk);
    if (mi < nMsg) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d messages", mi, nMsg);
    end
    repeat (10) @(negedge clk);
    chk(csN, "R5 idle after fault", int'(csN), 1);
    chk(nColl > 0, "R4 collisions exercised", nColl, 1);
    chk(ptr == nExp - 1, "R5 launches stop after fault", ptr, nExp - 1);
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end

endmodule